// File: doc/BRIEF.md
# Eight-Channel Pulse-Width Modulator with Pair Joining

This block produces eight left-aligned pulse-width modulated outputs from one shared clock prescaler. Each channel has an 8-bit counter, an 8-bit period and an 8-bit duty value. A channel's output is high while its counter is below the duty value. The counter returns to zero at the end of each period. Software programs the block through a simple register port: a write strobe with address and data, and a combinational read-data bus.

Adjacent channels can be joined into a single 16-bit channel. The pairs that can be joined are 2/3, 4/5 and 6/7. A joined pair is controlled only by the enable of its lower channel. It drives its waveform on the lower output and holds the upper output low. When every enable is clear, the prescaler holds its count at zero to save power.

An enable takes effect at the next prescaler tick, so the first period after enabling may be shortened. New period and duty values are held back until the channel's counter wraps, so a change never produces a partial pulse. The register port carries no stream of data, so it has no valid/ready handshake: every write is accepted in the cycle it is strobed.

Top module: `pwm8_cat`

## Requirements
- R1: After reset, every readable register returns 0 and `pwm_out` is all zeros.
- R2: The register map is: address 0 holds the enables (bit n for channel n), 1 holds the join controls, 2 holds the prescaler divisor, 3 returns the live prescaler count (read-only), 8+n holds channel n's period and 16+n holds channel n's duty. The enable register can be written and read back at any time.
- R3: A channel whose enable has just been set keeps its output low until the next prescaler tick. Its counter starts from 0 on the clock edge that ends that tick cycle.
- R4: In the join register, bit 0 joins channels 2/3, bit 1 joins 4/5 and bit 2 joins 6/7. A joined pair uses the upper channel's registers as the high byte and the lower channel's registers as the low byte of a 16-bit period and duty. The pair is enabled by the lower channel's enable bit, and its waveform appears on the lower channel's output.
- R5: While a pair is joined, the upper channel's enable bit has no effect and the upper output stays low.
- R6: While all eight enables are zero, the prescaler count reads 0 and does not change.
- R7: An enabled channel with period P and duty D is high for min(D,P) of every P ticks (P = 0 behaves as 1). The high ticks come first in each period.
- R8: Period and duty writes take effect only at the channel's next counter wrap, or when the channel starts.
- R9: Clearing a channel's enable drives its output low no later than the second clock edge after the write. Re-enabling restarts the counter from 0.
- R10: With divisor N, the prescaler ticks once every N+1 clocks while any channel is enabled. Its count runs from 0 to N and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` (combinational) |
| pwm_out | output | 8 | Modulated outputs, bit n for channel n |

## Verification
The bench measures the time from an enable write to the first high output with a divisor of 3. A design that started at once, or that ticked one count late, would show a high output four clocks too early or one clock too late. For a joined pair it programs a 256-tick period with a 128-tick duty and counts the high cycles. An unjoined 8-bit channel would be always high, and a design that obeyed the upper enable would light the upper output or start the pair without the lower bit. It changes the duty in the middle of a period, so a design without buffering would show a glitch pulse in that same period. It also checks that the prescaler count freezes at zero when every enable is clear, and it covers the period edge cases of zero, one, and a duty at or above the period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int AW = 5;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_EN   = 5'd0;
  localparam logic [AW-1:0] A_CAT  = 5'd1;
  localparam logic [AW-1:0] A_DIV  = 5'd2;
  localparam logic [AW-1:0] A_PCNT = 5'd3;
  localparam logic [AW-1:0] A_PER  = 5'd8;
  localparam logic [AW-1:0] A_DUTY = 5'd16;

  typedef logic [DW-1:0] byte_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int NCAT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  input  logic [DW-1:0]           pcnt,
  output logic [DW-1:0]           rdata,
  output logic [NCH-1:0]          en_q,
  output logic [NCAT-1:0]         cat_q,
  output logic [DW-1:0]           div_q,
  output logic [NCH-1:0][DW-1:0]  per_q,
  output logic [NCH-1:0][DW-1:0]  duty_q
);
  localparam int IW = $clog2(NCH);

  logic          sel_per;
  logic          sel_duty;
  logic [IW-1:0] idx;

  assign idx      = addr[IW-1:0];
  assign sel_per  = (addr[AW-1:IW] == A_PER[AW-1:IW]);
  assign sel_duty = (addr[AW-1:IW] == A_DUTY[AW-1:IW]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      cat_q  <= '0;
      div_q  <= '0;
      per_q  <= '0;
      duty_q <= '0;
    end else if (wr_en) begin
      if (addr == A_EN)  en_q  <= wdata[NCH-1:0];
      if (addr == A_CAT) cat_q <= wdata[NCAT-1:0];
      if (addr == A_DIV) div_q <= wdata;
      if (sel_per)       per_q[idx]  <= wdata;
      if (sel_duty)      duty_q[idx] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_EN)        rdata[NCH-1:0]  = en_q;
    else if (addr == A_CAT)  rdata[NCAT-1:0] = cat_q;
    else if (addr == A_DIV)  rdata = div_q;
    else if (addr == A_PCNT) rdata = pcnt;
    else if (sel_per)        rdata = per_q[idx];
    else if (sel_duty)       rdata = duty_q[idx];
  end

  // R2
  en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_EN) |=> (en_q == $past(wdata[NCH-1:0])));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] div,
  output logic          tick,
  output logic [PW-1:0] cnt
);
  localparam logic [PW-1:0] INC = PW'(1);

  logic at_end;
  assign at_end = (cnt >= div);
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (at_end) cnt <= '0;
    else             cnt <= cnt + INC;
  end

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  // R10
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic [W-1:0] per,
  input  logic [W-1:0] duty,
  output logic         out
);
  localparam logic [W-1:0] INC  = W'(1);
  localparam logic [W:0]   INCX = (W+1)'(1);

  logic         act;
  logic [W-1:0] cnt;
  logic [W-1:0] per_s;
  logic [W-1:0] duty_s;
  logic         wrap;

  assign wrap = (({1'b0, cnt} + INCX) >= {1'b0, per_s});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= 1'b0;
      cnt    <= '0;
      per_s  <= '0;
      duty_s <= '0;
    end else if (!en) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (tick) begin
      if (!act || wrap) begin
        act    <= 1'b1;
        cnt    <= '0;
        per_s  <= per;
        duty_s <= duty;
      end else begin
        cnt <= cnt + INC;
      end
    end
  end

  assign out = act && (cnt < duty_s);

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !tick) |=> !act);
  // R9
  dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out && cnt == '0));
  // R8
  hold_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !(tick && wrap)) |=> ($stable(per_s) && $stable(duty_s)));
  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && per_s != '0) |-> (cnt < per_s));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter bit HAS_CAT = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en_lo,
  input  logic       en_hi,
  input  logic       cat,
  input  logic [7:0] per_lo,
  input  logic [7:0] per_hi,
  input  logic [7:0] duty_lo,
  input  logic [7:0] duty_hi,
  output logic       out_lo,
  output logic       out_hi
);
  logic o_lo8;
  logic o_hi8;
  logic cat_eff;

  assign cat_eff = HAS_CAT ? cat : 1'b0;

  pwm_chan #(.W(8)) u_lo (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_lo & ~cat_eff),
    .per(per_lo), .duty(duty_lo), .out(o_lo8)
  );

  pwm_chan #(.W(8)) u_hi (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_hi & ~cat_eff),
    .per(per_hi), .duty(duty_hi), .out(o_hi8)
  );

  generate
    if (HAS_CAT) begin : g_cat
      logic o_w;
      pwm_chan #(.W(16)) u_wide (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_lo & cat),
        .per({per_hi, per_lo}), .duty({duty_hi, duty_lo}), .out(o_w)
      );
      assign out_lo = cat ? o_w  : o_lo8;
      assign out_hi = cat ? 1'b0 : o_hi8;

      // R5
      hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cat |=> !o_hi8);
      // R4
      lo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cat && !en_lo) |=> !o_w);
    end else begin : g_plain
      logic unused_cat;
      assign unused_cat = cat;
      assign out_lo = o_lo8;
      assign out_hi = o_hi8;
    end
  endgenerate
endmodule

// File: rtl/pwm8_cat.sv
module pwm8_cat
  import pwm_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int NPAIR = NCH / 2;
  localparam int NCAT  = NPAIR - 1;

  logic [NCH-1:0]         en_q;
  logic [NCAT-1:0]        cat_q;
  logic [DW-1:0]          div_q;
  logic [NCH-1:0][DW-1:0] per_q;
  logic [NCH-1:0][DW-1:0] duty_q;
  logic [DW-1:0]          pcnt;
  logic                   tick;
  logic [NPAIR-1:0]       cat_vec;

  assign cat_vec = {cat_q, 1'b0};

  pwm_regs #(.NCH(NCH), .NCAT(NCAT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pcnt(pcnt), .rdata(rdata), .en_q(en_q), .cat_q(cat_q), .div_q(div_q),
    .per_q(per_q), .duty_q(duty_q)
  );

  pwm_prescaler #(.PW(DW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(|en_q), .div(div_q), .tick(tick), .cnt(pcnt)
  );

  generate
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      pwm_pair #(.HAS_CAT(p != 0)) u_pair (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .en_lo(en_q[2*p]), .en_hi(en_q[2*p+1]), .cat(cat_vec[p]),
        .per_lo(per_q[2*p]), .per_hi(per_q[2*p+1]),
        .duty_lo(duty_q[2*p]), .duty_hi(duty_q[2*p+1]),
        .out_lo(pwm_out[2*p]), .out_hi(pwm_out[2*p+1])
      );
    end
  endgenerate

  // R1
  rst_out_chk: assert property (@(posedge clk) !rst_n |=> (pwm_out == '0));
endmodule

// File: tb/tb_pwm8_cat.sv
module tb_pwm8_cat;
  import pwm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  pwm_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm8_cat dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  // {period, duty, window, expected high cycles} for channel 0, divisor 0 (R7)
  localparam logic [31:0] VEC [7] = '{
    {8'd10, 8'd3, 8'd40, 8'd12},
    {8'd8,  8'd0, 8'd32, 8'd0},
    {8'd5,  8'd5, 8'd20, 8'd20},
    {8'd6,  8'd9, 8'd24, 8'd24},
    {8'd1,  8'd1, 8'd8,  8'd8},
    {8'd0,  8'd0, 8'd8,  8'd0},
    {8'd7,  8'd4, 8'd28, 8'd16}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count high cycles of one output over n negedges
  task automatic count_hi(input int bitn, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out[bitn]) hi++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : main
    logic [7:0] d;
    int hi, hi3, hi_first, hi_second;

    step(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(pwm_out == 8'h00, "R1 out", pwm_out, 0);
    rd(A_EN, d);   chk(d == 8'h00, "R1 enable reg", d, 0);
    rd(A_CAT, d);  chk(d == 8'h00, "R1 join reg", d, 0);
    rd(A_PCNT, d); chk(d == 8'h00, "R1 prescaler count", d, 0);
    rd(5'd8, d);   chk(d == 8'h00, "R1 period0", d, 0);

    // R2: enable register write/readback, period/duty map
    wr(A_EN, 8'hA5);
    rd(A_EN, d); chk(d == 8'hA5, "R2 enable readback", d, 8'hA5);
    wr(A_EN, 8'h00);
    wr(5'd13, 8'h3C);
    rd(5'd13, d); chk(d == 8'h3C, "R2 period5 readback", d, 8'h3C);
    wr(5'd22, 8'h7E);
    rd(5'd22, d); chk(d == 8'h7E, "R2 duty6 readback", d, 8'h7E);

    // R6: prescaler frozen while all enables clear
    wr(A_DIV, 8'd3);
    step(5);
    rd(A_PCNT, d); chk(d == 8'h00, "R6 idle count", d, 0);

    // R3/R10: enable latency with divisor 3
    wr(5'd8, 8'd4);
    wr(5'd16, 8'd2);
    wr(A_EN, 8'h01);                    // edge k
    rd(A_PCNT, d); chk(d == 8'h00, "R10 count after k", d, 0);
    chk(pwm_out[0] == 1'b0, "R3 low before tick", pwm_out[0], 0);
    step(3);                            // after k+3
    rd(A_PCNT, d); chk(d == 8'd3, "R10 count at divisor", d, 3);
    chk(pwm_out[0] == 1'b0, "R3 low until tick", pwm_out[0], 0);
    step(1);                            // after k+4
    chk(pwm_out[0] == 1'b1, "R3 high after tick", pwm_out[0], 1);
    rd(A_PCNT, d); chk(d == 8'h00, "R10 count wraps", d, 0);

    // R9/R6: disable
    wr(A_EN, 8'h00);
    step(1);
    chk(pwm_out == 8'h00, "R9 out low after disable", pwm_out, 0);
    step(4);
    rd(A_PCNT, d); chk(d == 8'h00, "R6 count frozen after disable", d, 0);
    chk(pwm_out == 8'h00, "R9 out stays low", pwm_out, 0);

    // R7: table of period/duty vectors on channel 0, divisor 0
    wr(A_DIV, 8'd0);
    for (int v = 0; v < 7; v++) begin
      wr(A_EN, 8'h00);
      wr(5'd8,  VEC[v][31:24]);
      wr(5'd16, VEC[v][23:16]);
      wr(A_EN, 8'h01);
      @(negedge clk);
      count_hi(0, int'(VEC[v][15:8]), hi);
      chk(hi == int'(VEC[v][7:0]), $sformatf("R7 vector %0d", v), hi, int'(VEC[v][7:0]));
    end

    // R8: duty change mid-period is deferred to the wrap
    wr(A_EN, 8'h00);
    wr(5'd8, 8'd10);
    wr(5'd16, 8'd3);
    wr(A_EN, 8'h01);
    @(negedge clk);
    hi_first = 0; hi_second = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwm_out[0]) begin
        if (i < 10) hi_first++; else hi_second++;
      end
      if (i == 5) begin wr_en = 1'b1; addr = 5'd16; wdata = 8'd7; end
      else wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk(hi_first == 3, "R8 old duty kept this period", hi_first, 3);
    chk(hi_second == 7, "R8 new duty next period", hi_second, 7);

    // R9: re-enable restarts from 0 (first cycle high again)
    wr(A_EN, 8'h00);
    wr(A_EN, 8'h01);
    @(negedge clk);
    chk(pwm_out[0] == 1'b1, "R9 restart at count 0", pwm_out[0], 1);
    wr(A_EN, 8'h00);

    // R4: join pair 2/3 into 16-bit period 256, duty 128
    wr(A_CAT, 8'h01);
    wr(5'd10, 8'h00); wr(5'd11, 8'h01);
    wr(5'd18, 8'h80); wr(5'd19, 8'h00);
    wr(A_EN, 8'h04);
    @(negedge clk);
    hi3 = 0; hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out[2]) hi++;
      if (pwm_out[3]) hi3++;
      @(negedge clk);
    end
    chk(hi == 128, "R4 joined duty on low output", hi, 128);
    chk(hi3 == 0, "R5 upper output low while joined", hi3, 0);

    // R5: upper enable alone has no effect
    wr(A_EN, 8'h00);
    wr(A_EN, 8'h08);
    step(2);
    count_hi(2, 32, hi);
    chk(hi == 0, "R5 upper enable ignored (low out)", hi, 0);
    count_hi(3, 32, hi3);
    chk(hi3 == 0, "R5 upper enable ignored (upper out)", hi3, 0);

    // R5: both enables set behaves as low enable only
    wr(A_EN, 8'h00);
    wr(A_EN, 8'h0C);
    @(negedge clk);
    hi3 = 0; hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out[2]) hi++;
      if (pwm_out[3]) hi3++;
      @(negedge clk);
    end
    chk(hi == 128, "R5 both enables joined duty", hi, 128);
    chk(hi3 == 0, "R5 both enables upper low", hi3, 0);

    // R4: unjoined, the same registers act as 8-bit channels (period 0 -> always high for duty 0x80)
    wr(A_EN, 8'h00);
    wr(A_CAT, 8'h00);
    wr(A_EN, 8'h04);
    @(negedge clk);
    count_hi(2, 16, hi);
    chk(hi == 16, "R4 unjoined 8-bit behaviour", hi, 16);

    // R4: join bit 2 pairs 6/7
    wr(A_EN, 8'h00);
    wr(A_CAT, 8'h04);
    wr(5'd14, 8'h00); wr(5'd15, 8'h01);
    wr(5'd22, 8'h40); wr(5'd23, 8'h00);
    wr(A_EN, 8'hC0);
    @(negedge clk);
    hi3 = 0; hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_out[6]) hi++;
      if (pwm_out[7]) hi3++;
      @(negedge clk);
    end
    chk(hi == 64, "R4 pair 6/7 joined duty", hi, 64);
    chk(hi3 == 0, "R5 pair 6/7 upper low", hi3, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule